// File: doc/BRIEF.md
# Burst Memory Self-Test Engine

This block exercises a burst memory controller through its user command port with no processor involved. Once the controller reports that initialization is complete, the engine writes a fixed number of bursts to a contiguous address window. It then reads the same window back and compares every returned word against a value that it generates again from the burst address and the beat index. Because of this, no copy of the written data is ever stored.

Commands leave the engine at a fixed pitch that depends on the configured burst length. Write data for each burst is presented on back-to-back cycles, starting in the cycle of the command. Read data is taken only in cycles where the controller flags it valid and a word is still owed. When the last expected word has been compared, the engine raises a completion flag, a pass/fail verdict and a saturating mismatch count. A stall watchdog also ends the run with a failure if returned data stops arriving.

Top module: `burst_mem_selftest`

## Requirements
- R1: No command is issued until `init_done` has been sampled high at a rising clock edge. The first command enable appears in the cycle that follows that edge, and `init_done` is ignored after that.
- R2: The engine issues N_BURSTS write commands (`cmd`=1) and then N_BURSTS read commands (`cmd`=0). Each command is a single-cycle `cmd_en` pulse. Within each phase, the k-th command (k from 0) carries address BASE_ADDR + k*BURST_LEN/2. While `cmd_en` is low, `cmd` and `addr` are zero.
- R3: Consecutive `cmd_en` pulses are exactly BURST_LEN/4 + 11 cycles apart. This gives 15, 19, 27 and 43 cycles for bursts of 16, 32, 64 and 128.
- R4: A write burst supplies BURST_LEN/4 words on `wr_data` on consecutive cycles, with beat 0 in the cycle of its command. In every other cycle `wr_data` is zero.
- R5: `wr_mask` is zero in every cycle.
- R6: The word for burst address A and beat b is built as follows. Let s = ((A*256) + b) XOR 32'h5A5AC3C3, truncated to 32 bits. The word is (s >> 1) XOR 32'h80200003 when bit 0 of s is 1, and s >> 1 otherwise. Read words are checked against the same function, taken in command order and beat order.
- R7: A read word is consumed only at an edge where `rd_valid` is high, at least one issued read word has not yet returned, and `done` is low. Valid beats at any other time change no output.
- R8: Each consumed word that differs from its expected value raises `fail`, which then stays set. It also adds one to `err_cnt`, which holds at its all-ones maximum. A nonzero `err_cnt` always comes with `fail`.
- R9: `done` rises in the cycle after the last expected word is consumed and stays high until reset. `pass` equals `done` with `fail` low.
- R10: Words may be owed while `done` is low. If WD_LIMIT consecutive edges then pass with no word consumed, `timed_out`, `fail` and `done` rise after the WD_LIMIT-th such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Controller initialization complete |
| cmd_en | output | 1 | Command strobe, one cycle per command |
| cmd | output | 1 | 1 = write, 0 = read |
| addr | output | ADDR_W | Burst start address |
| wr_data | output | 4*DQ_W | Write data beat |
| wr_mask | output | 4*DQ_W/8 | Byte mask, always zero |
| rd_data | input | 4*DQ_W | Returned read word |
| rd_valid | input | 1 | Returned word valid |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no error and no stall |
| fail | output | 1 | Sticky failure flag |
| timed_out | output | 1 | Read data stall detected |
| err_cnt | output | ERR_W | Saturating mismatch count |

## Verification
A wrong phase state or burst counter shows up at the command port within one command pitch, as a missing strobe, an early strobe or a wrong address. A wrong beat counter on the write side shows up in the very next `wr_data` word. On the read side, the owed-word count and the expected-word pointer only become visible at `err_cnt`, `fail`, `done` or `timed_out`. A slip in either of them produces a mismatch on the next valid beat. It also moves the completion or stall edge by one or more cycles. The bench therefore compares every output against its model on every clock, including runs with corrupted, missing and unsolicited read beats.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_READ, SQ_END} sq_state_e;

  // spacing between command strobes for a given burst length
  function automatic int unsigned cmd_gap(input int unsigned burst_len);
    return burst_len / 4 + 11;
  endfunction
endpackage

// File: rtl/tg_rst_sync.sv
`timescale 1ns/1ps
module tg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tg_pattern.sv
`timescale 1ns/1ps
module tg_pattern #(
  parameter int ADDR_W = 22,
  parameter int BEAT_W = 2,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SALT = 32'h5A5AC3C3,
  parameter logic [DATA_W-1:0] TAPS = 32'h80200003
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] seed;

  always_comb begin
    seed   = ((DATA_W'(addr_i) << 8) | DATA_W'(beat_i)) ^ SALT;
    word_o = (seed >> 1) ^ (seed[0] ? TAPS : '0);
  end
endmodule

// File: rtl/tg_sequencer.sv
`timescale 1ns/1ps
module tg_sequencer
  import tg_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 32,
  parameter int BEATS     = 4,
  parameter int N_BURSTS  = 4,
  parameter int GAP       = 15,
  parameter int STEP      = 8,
  parameter int BASE_ADDR = 0,
  parameter logic [DATA_W-1:0] SALT = 32'h5A5AC3C3,
  parameter logic [DATA_W-1:0] TAPS = 32'h80200003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done_i,
  output logic              cmd_en_o,
  output logic              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_issue_o
);
  localparam int GAP_W  = $clog2(GAP);
  localparam int OP_W   = (N_BURSTS > 1) ? $clog2(N_BURSTS) : 1;
  localparam int BEAT_W = $clog2(BEATS);

  sq_state_e         st_q, st_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic              wb_act_q, wb_act_d;
  logic [BEAT_W-1:0] wb_beat_q, wb_beat_d;
  logic [ADDR_W-1:0] wb_addr_q, wb_addr_d;
  logic              issue, wr_issue;
  logic [ADDR_W-1:0] cur_addr, pat_addr;
  logic [BEAT_W-1:0] pat_beat;
  logic [DATA_W-1:0] pat_word;

  // command pacing and phase control
  always_comb begin
    issue    = ((st_q == SQ_WRITE) || (st_q == SQ_READ)) && (gap_q == '0);
    wr_issue = issue && (st_q == SQ_WRITE);
    cur_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(op_q) * ADDR_W'(STEP);
    st_d  = st_q;
    gap_d = gap_q;
    op_d  = op_q;
    if (st_q == SQ_IDLE) begin
      if (init_done_i) begin
        st_d  = SQ_WRITE;
        gap_d = '0;
        op_d  = '0;
      end
    end else if (issue) begin
      gap_d = GAP_W'(GAP - 1);
      if (op_q == OP_W'(N_BURSTS - 1)) begin
        op_d = '0;
        st_d = (st_q == SQ_WRITE) ? SQ_READ : SQ_END;
      end else begin
        op_d = op_q + 1'b1;
      end
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end
  end

  // write beat sequencing
  always_comb begin
    wb_act_d  = wb_act_q;
    wb_beat_d = wb_beat_q;
    wb_addr_d = wb_addr_q;
    if (wr_issue) begin
      wb_act_d  = 1'b1;
      wb_beat_d = BEAT_W'(1);
      wb_addr_d = cur_addr;
    end else if (wb_act_q) begin
      if (wb_beat_q == BEAT_W'(BEATS - 1)) wb_act_d  = 1'b0;
      else                                 wb_beat_d = wb_beat_q + 1'b1;
    end
    pat_addr = wr_issue ? cur_addr : wb_addr_q;
    pat_beat = wr_issue ? '0 : wb_beat_q;
  end

  tg_pattern #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .DATA_W(DATA_W), .SALT(SALT), .TAPS(TAPS)
  ) wr_pat_i (
    .addr_i(pat_addr), .beat_i(pat_beat), .word_o(pat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      gap_q     <= '0;
      op_q      <= '0;
      wb_act_q  <= 1'b0;
      wb_beat_q <= '0;
      wb_addr_q <= '0;
    end else begin
      st_q      <= st_d;
      gap_q     <= gap_d;
      op_q      <= op_d;
      wb_act_q  <= wb_act_d;
      wb_beat_q <= wb_beat_d;
      wb_addr_q <= wb_addr_d;
    end
  end

  assign cmd_en_o   = issue;
  assign cmd_o      = wr_issue;
  assign addr_o     = issue ? cur_addr : '0;
  assign wr_data_o  = (wr_issue || wb_act_q) ? pat_word : '0;
  assign rd_issue_o = issue && (st_q == SQ_READ);
endmodule

// File: rtl/tg_rd_check.sv
`timescale 1ns/1ps
module tg_rd_check #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 32,
  parameter int BEATS     = 4,
  parameter int N_BURSTS  = 4,
  parameter int STEP      = 8,
  parameter int BASE_ADDR = 0,
  parameter int ERR_W     = 4,
  parameter int WD_LIMIT  = 64,
  parameter logic [DATA_W-1:0] SALT = 32'h5A5AC3C3,
  parameter logic [DATA_W-1:0] TAPS = 32'h80200003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              tmo_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam int TOTAL  = N_BURSTS * BEATS;
  localparam int OWE_W  = $clog2(TOTAL + 1);
  localparam int OP_W   = (N_BURSTS > 1) ? $clog2(N_BURSTS) : 1;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int WD_W   = $clog2(WD_LIMIT);

  logic [OWE_W-1:0]  owed_q, owed_d;
  logic [OP_W-1:0]   rb_q, rb_d;
  logic [BEAT_W-1:0] rbeat_q, rbeat_d;
  logic [WD_W-1:0]   wd_q, wd_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              done_q, done_d, fail_q, fail_d, tmo_q, tmo_d;
  logic              accept, mismatch, last, wd_run, wd_hit;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_word;

  always_comb exp_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(rb_q) * ADDR_W'(STEP);

  tg_pattern #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .DATA_W(DATA_W), .SALT(SALT), .TAPS(TAPS)
  ) rd_pat_i (
    .addr_i(exp_addr), .beat_i(rbeat_q), .word_o(exp_word)
  );

  always_comb begin
    accept   = rd_valid_i && (owed_q != '0) && !done_q;
    mismatch = accept && (rd_data_i != exp_word);
    last     = accept && (rb_q == OP_W'(N_BURSTS - 1)) && (rbeat_q == BEAT_W'(BEATS - 1));
    wd_run   = (owed_q != '0) && !done_q && !accept;
    wd_hit   = wd_run && (wd_q == WD_W'(WD_LIMIT - 1));

    owed_d = owed_q + (rd_issue_i ? OWE_W'(BEATS) : OWE_W'(0)) - (accept ? OWE_W'(1) : OWE_W'(0));

    rb_d    = rb_q;
    rbeat_d = rbeat_q;
    if (accept) begin
      if (rbeat_q == BEAT_W'(BEATS - 1)) begin
        rbeat_d = '0;
        rb_d    = rb_q + 1'b1;
      end else begin
        rbeat_d = rbeat_q + 1'b1;
      end
    end

    err_d  = (mismatch && (err_q != '1)) ? err_q + 1'b1 : err_q;
    fail_d = fail_q | mismatch | wd_hit;
    tmo_d  = tmo_q | wd_hit;
    done_d = done_q | last | wd_hit;
    wd_d   = wd_run ? (wd_hit ? wd_q : wd_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q  <= '0;
      rb_q    <= '0;
      rbeat_q <= '0;
      wd_q    <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      owed_q  <= owed_d;
      rb_q    <= rb_d;
      rbeat_q <= rbeat_d;
      wd_q    <= wd_d;
      err_q   <= err_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;
  assign tmo_o  = tmo_q;
  assign err_o  = err_q;
endmodule

// File: rtl/burst_mem_selftest.sv
`timescale 1ns/1ps
module burst_mem_selftest
  import tg_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DQ_W      = 8,
  parameter int BURST_LEN = 16,
  parameter int N_BURSTS  = 4,
  parameter int BASE_ADDR = 256,
  parameter int ERR_W     = 4,
  parameter int WD_LIMIT  = 64,
  parameter logic [4*DQ_W-1:0] SALT = 32'h5A5AC3C3,
  parameter logic [4*DQ_W-1:0] TAPS = 32'h80200003
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_done,
  output logic                cmd_en,
  output logic                cmd,
  output logic [ADDR_W-1:0]   addr,
  output logic [4*DQ_W-1:0]   wr_data,
  output logic [4*DQ_W/8-1:0] wr_mask,
  input  logic [4*DQ_W-1:0]   rd_data,
  input  logic                rd_valid,
  output logic                done,
  output logic                pass,
  output logic                fail,
  output logic                timed_out,
  output logic [ERR_W-1:0]    err_cnt
);
  localparam int DATA_W = 4 * DQ_W;
  localparam int BEATS  = BURST_LEN / 4;
  localparam int STEP   = BURST_LEN / 2;
  localparam int GAP    = int'(cmd_gap(BURST_LEN));

  logic core_rst_n;
  logic rd_issue;

  tg_rst_sync rst_i (.clk(clk), .arst_n(rst_n), .rst_n_o(core_rst_n));

  tg_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .N_BURSTS(N_BURSTS),
    .GAP(GAP), .STEP(STEP), .BASE_ADDR(BASE_ADDR), .SALT(SALT), .TAPS(TAPS)
  ) seq_i (
    .clk(clk), .rst_n(core_rst_n), .init_done_i(init_done),
    .cmd_en_o(cmd_en), .cmd_o(cmd), .addr_o(addr), .wr_data_o(wr_data),
    .rd_issue_o(rd_issue)
  );

  tg_rd_check #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .N_BURSTS(N_BURSTS),
    .STEP(STEP), .BASE_ADDR(BASE_ADDR), .ERR_W(ERR_W), .WD_LIMIT(WD_LIMIT),
    .SALT(SALT), .TAPS(TAPS)
  ) chk_i (
    .clk(clk), .rst_n(core_rst_n), .rd_issue_i(rd_issue),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .done_o(done), .fail_o(fail), .tmo_o(timed_out), .err_o(err_cnt)
  );

  assign wr_mask = '0;
  assign pass    = done & ~fail;
endmodule

// File: rtl/burst_mem_selftest_sva.sv
`timescale 1ns/1ps
module burst_mem_selftest_sva #(
  parameter int GAP    = 15,
  parameter int ADDR_W = 22,
  parameter int MASK_W = 4,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic              cmd_en,
  input logic              cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [MASK_W-1:0] wr_mask,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              timed_out,
  input logic [ERR_W-1:0]  err_cnt
);
  localparam int SINCE_W = $clog2(GAP + 1);

  logic               init_seen_q, seen_q;
  logic [SINCE_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_seen_q <= 1'b0;
      seen_q      <= 1'b0;
      since_q     <= '0;
    end else begin
      if (init_done) init_seen_q <= 1'b1;
      if (cmd_en) begin
        seen_q  <= 1'b1;
        since_q <= '0;
      end else if (since_q != SINCE_W'(GAP)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  AST_START_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> init_seen_q); // R1
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (addr == '0) && !cmd); // R2
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && seen_q) |-> (since_q >= SINCE_W'(GAP - 1))); // R3
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask == '0); // R5
  AST_ERR_FLAGS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> fail); // R8
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1) |=> (err_cnt == '1)); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !fail)); // R9
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (done && fail)); // R10
endmodule

bind burst_mem_selftest burst_mem_selftest_sva #(
  .GAP(GAP), .ADDR_W(ADDR_W), .MASK_W(4*DQ_W/8), .ERR_W(ERR_W)
) sva_i (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .cmd_en(cmd_en), .cmd(cmd),
  .addr(addr), .wr_mask(wr_mask), .done(done), .pass(pass), .fail(fail),
  .timed_out(timed_out), .err_cnt(err_cnt)
);

// File: tb/burst_mem_selftest_tb_top.sv
`timescale 1ns/1ps
module burst_mem_selftest_tb_top;
  localparam int ADDR_W = 22, DQ_W = 8, BURST_LEN = 16, N_BURSTS = 4;
  localparam int BASE = 256, ERR_W = 4, WD_LIMIT = 64;
  localparam int DATA_W = 32, MASK_W = 4, BEATS = 4, STEP = 8, GAP = 15;
  localparam int TOTAL = N_BURSTS * BEATS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, init_done, cmd_en, cmd, rd_valid;
  logic              done, pass, fail, timed_out;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [MASK_W-1:0] wr_mask;
  logic [ERR_W-1:0]  err_cnt;

  burst_mem_selftest #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .BURST_LEN(BURST_LEN), .N_BURSTS(N_BURSTS),
    .BASE_ADDR(BASE), .ERR_W(ERR_W), .WD_LIMIT(WD_LIMIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cmd_en(cmd_en), .cmd(cmd),
    .addr(addr), .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .pass(pass), .fail(fail),
    .timed_out(timed_out), .err_cnt(err_cnt)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] mem [int];
  int          rq_t[$];
  logic [31:0] rq_d[$];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // data word per R6
  function automatic logic [31:0] pat(input int a, input int b);
    logic [31:0] s;
    s = ((32'(a) * 32'd256) + 32'(b)) ^ 32'h5A5AC3C3;
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  // mode 1: clean + stray valids, 2: two bad words, 3: all bad, 4: last word lost
  task automatic run_test(input int mode, input int init_at);
    int n, start, owed, rcv, err_m, idle, done_at, gidx, e, k, b;
    bit fail_m, done_m, tmo_m, pv, pir;
    logic [31:0] pd, ex, w;
    logic        e_en, e_cmd;
    logic [31:0] e_addr, e_wd;
    rst_n = 1'b0; init_done = 1'b0; rd_valid = 1'b0; rd_data = '0;
    rq_t.delete(); rq_d.delete(); mem.delete();
    repeat (3) @(negedge clk);
    check("R2", "reset cmd_en", cmd_en, 0);
    check("R9", "reset done", done, 0);
    check("R8", "reset err_cnt", err_cnt, 0);
    rst_n = 1'b1;
    n = 0; start = -1; owed = 0; rcv = 0; err_m = 0; idle = 0; done_at = 0; gidx = 0;
    fail_m = 0; done_m = 0; tmo_m = 0; pv = 0; pir = 0; pd = '0;
    e = 0; k = 0; b = 0;
    while (!(done_m && n >= done_at + 8) && n < 2000) begin
      @(negedge clk);
      n++;
      // model of the edge just passed
      if (pv && owed > 0 && !done_m) begin
        ex = pat(BASE + (rcv / BEATS) * STEP, rcv % BEATS);
        if (pd !== ex) begin fail_m = 1; if (err_m < 15) err_m++; end
        rcv++; owed--; idle = 0;
        if (rcv == TOTAL) begin done_m = 1; done_at = n; end
      end else if (owed > 0 && !done_m) begin
        idle++;
        if (idle == WD_LIMIT) begin tmo_m = 1; fail_m = 1; done_m = 1; done_at = n; end
      end else begin
        idle = 0;
      end
      if (pir) owed += BEATS;
      // expected command side
      e_en = 0; e_cmd = 0; e_addr = '0; e_wd = '0;
      if (start >= 0 && n >= start) begin
        e = n - start; k = e / GAP; b = e % GAP;
        if (k < 2 * N_BURSTS && b == 0) begin
          e_en = 1; e_cmd = (k < N_BURSTS); e_addr = BASE + (k % N_BURSTS) * STEP;
        end
        if (k < N_BURSTS && b < BEATS) e_wd = pat(BASE + k * STEP, b);
      end
      if (start < 0) check("R1", "cmd_en before init", cmd_en, 0);
      else           check("R3", "cmd_en pitch", cmd_en, e_en);
      check("R2", "cmd", cmd, e_cmd);
      check("R2", "addr", addr, e_addr);
      check("R4 R6", "wr_data", wr_data, e_wd);
      check("R5", "wr_mask", wr_mask, 0);
      check("R7 R8", "err_cnt", err_cnt, err_m);
      check("R8", "fail", fail, fail_m);
      check("R9", "done", done, done_m);
      check("R9", "pass", pass, done_m && !fail_m);
      check("R10", "timed_out", timed_out, tmo_m);
      // memory model
      if (start >= 0 && n >= start && k < N_BURSTS && b < BEATS) mem[BASE + k * STEP + b] = wr_data;
      pir = cmd_en && !cmd;
      if (cmd_en && !cmd) begin
        for (int bb = 0; bb < BEATS; bb++) begin
          w = mem.exists(int'(addr) + bb) ? mem[int'(addr) + bb] : 32'hBAD0BAD0;
          if (mode == 2 && (gidx == 1 || gidx == 6)) w = w ^ 32'h10;
          if (mode == 3) w = w ^ 32'h1;
          if (!(mode == 4 && gidx == TOTAL - 1)) begin
            rq_t.push_back(n + 3 + bb + ((bb >= 2) ? 1 : 0));
            rq_d.push_back(w);
          end
          gidx++;
        end
      end
      // drive inputs
      if (n == init_at) begin init_done = 1'b1; start = n + 1; end
      if (rq_t.size() > 0 && rq_t[0] == n) begin
        rd_valid = 1'b1; rd_data = rq_d.pop_front(); void'(rq_t.pop_front());
      end else if (mode == 1 && ((start >= 0 && n == start + 4) ||
                                 (done_m && n >= done_at + 2 && n <= done_at + 4))) begin
        rd_valid = 1'b1; rd_data = 32'hFFFF0000 ^ 32'(n);
      end else begin
        rd_valid = 1'b0; rd_data = '0;
      end
      pv = rd_valid; pd = rd_data;
    end
    check("R9", "run finished", done, 1);
    check("R9", "final pass", pass, (mode == 1) ? 1 : 0);
    check("R8", "final err_cnt", err_cnt, (mode == 2) ? 2 : ((mode == 3) ? 15 : 0));
    check("R10", "final timed_out", timed_out, (mode == 4) ? 1 : 0);
  endtask

  initial begin
    run_test(1, 9);
    run_test(2, 5);
    run_test(3, 6);
    run_test(4, 7);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule